// File: doc/BRIEF.md
# Sectioned Binary Divider Chain

This block is a 24-stage binary divider built as a synchronous counter. Each falling edge of the slow input clock is presented as a one-cycle `count_en` strobe in the system clock domain. In normal mode every stage toggles at half the rate of the stage below it. The chain as a whole divides the strobe rate by 2^24. Only the top seven stages, stage 18 through stage 24, leave the block as divided outputs. The full count is also available on a debug port.

A test-mode input splits the chain into three 8-bit sections that all advance on the same strobe. This lets a short sequence reach every stage. After a reset, 255 test-mode strobes set every stage to one. One more strobe in normal mode then has to carry the whole chain back to zero, which crosses both section boundaries.

An active-high asynchronous reset clears all stages. It also raises a hold flag that a surrounding clock source can use to stop oscillating while the block is idle.

Top module: `divchain_top`

## Requirements
- R1: While `rst` is high, `count_dbg` is 0 and `tap_out` is 0. Asserting `rst` at any point clears the count at once.
- R2: `osc_hold` is 1 while `rst` is high. It stays 1 until the first rising `clk` edge after `rst` falls, and it is 0 from that edge on.
- R3: With `test_mode`=0, a `count_en` pulse that is sampled high raises `count_dbg` by exactly 1, modulo 2^24. A cycle with `count_en` low leaves the count unchanged.
- R4: `tap_out[k]` equals count bit 17+k. Bit 0 is stage 18 (divide by 2^18) and bit 6 is stage 24 (divide by 2^24).
- R5: With `test_mode`=1, each strobe adds 1 independently to count bits [7:0], [15:8] and [23:16]. Each section wraps from 255 to 0, and no carry passes into the next section.
- R6: Starting from reset, 255 strobes with `test_mode`=1 give `count_dbg`=24'hFFFFFF. One further strobe with `test_mode`=0 gives 0.
- R7: Changing `test_mode` with no strobe present leaves the count unchanged.
- R8: `count_en` pulses while `rst` is high have no effect; the count stays 0.
- R9: In normal mode, carries cross the section boundaries. For example, 24'h0000FF becomes 24'h000100, and 24'h00FFFF becomes 24'h010000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| count_en | input | 1 | One-cycle strobe that stands for one falling input-clock edge |
| test_mode | input | 1 | 1 = three parallel 8-bit sections, 0 = one 24-bit chain |
| tap_out | output | 7 | Stage 18 to stage 24 outputs |
| count_dbg | output | 24 | Full stage contents for debug |
| osc_hold | output | 1 | Request to stop the clock source, raised by reset |

## Verification
The stages are registered on the rising `clk` edge at which `count_en` is sampled. Every count and tap result is therefore due one cycle after a strobe is driven. The scoreboard drives stimulus on the falling edge and queues the expected count. The monitor pops that entry and compares it 1 ns after the next rising edge, so each expected value lines up with exactly that edge. Reset results are checked without waiting for a clock, because the reset is asynchronous. `osc_hold` is checked twice after reset release: once before the first rising edge, when it must still be 1, and once just after that edge, when it must be 0.

// File: rtl/divchain_pkg.sv
package divchain_pkg;
   typedef enum logic {
      CHAIN_SERIAL    = 1'b0,
      CHAIN_SECTIONED = 1'b1
   } chain_mode_e;

   function automatic int tap_count(input int stages, input int first_tap);
      return stages - first_tap + 1;
   endfunction
endpackage

// File: rtl/divchain_section.sv
module divchain_section #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   output logic [W-1:0] q,
   output logic         carry
);
   if (W < 1) begin : g_bad_w
      $error("divchain_section: W must be at least 1");
   end

   logic [W-1:0] q_r;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)      q_r <= '0;
      else if (inc) q_r <= q_r + W'(1);
   end

   assign q     = q_r;
   assign carry = inc & (&q_r);
endmodule

// File: rtl/divchain_link.sv
module divchain_link #(
   parameter bit ALLOW_SECTIONS = 1'b1
) (
   input  logic                      strobe,
   input  logic                      prev_carry,
   input  divchain_pkg::chain_mode_e mode,
   output logic                      inc
);
   import divchain_pkg::*;

   if (ALLOW_SECTIONS) begin : g_split
      always_comb begin
         if (mode == CHAIN_SECTIONED) inc = strobe;
         else                         inc = prev_carry;
      end
   end else begin : g_serial
      logic unused_ok;
      assign unused_ok = strobe ^ mode;
      assign inc = prev_carry;
   end
endmodule

// File: rtl/divchain_osc_gate.sv
module divchain_osc_gate (
   input  logic clk,
   input  logic rst,
   output logic hold
);
   logic hold_r;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) hold_r <= 1'b1;
      else     hold_r <= 1'b0;
   end

   assign hold = hold_r;
endmodule

// File: rtl/divchain_top.sv
module divchain_top #(
   parameter int SECT_W         = 8,
   parameter int N_SECT         = 3,
   parameter int FIRST_TAP      = 18,
   parameter bit ALLOW_SECTIONS = 1'b1,
   localparam int STAGES        = SECT_W * N_SECT,
   localparam int TAP_N         = STAGES - FIRST_TAP + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              count_en,
   input  logic              test_mode,
   output logic [TAP_N-1:0]  tap_out,
   output logic [STAGES-1:0] count_dbg,
   output logic              osc_hold
);
   import divchain_pkg::*;

   if (N_SECT < 1) begin : g_bad_sect
      $error("divchain_top: N_SECT must be at least 1");
   end
   if (FIRST_TAP < 1 || FIRST_TAP > STAGES) begin : g_bad_tap
      $error("divchain_top: FIRST_TAP out of range");
   end
   if (TAP_N != tap_count(STAGES, FIRST_TAP)) begin : g_bad_tapn
      $error("divchain_top: tap width mismatch");
   end

   chain_mode_e             mode;
   logic [N_SECT-1:0]       sect_inc;
   logic [N_SECT-1:0]       sect_carry;
   logic [STAGES-1:0]       stages_q;

   assign mode = chain_mode_e'(test_mode);

   for (genvar s = 0; s < N_SECT; s++) begin : g_sect
      if (s == 0) begin : g_first
         assign sect_inc[s] = count_en;
      end else begin : g_next
         divchain_link #(
            .ALLOW_SECTIONS(ALLOW_SECTIONS)
         ) link_i (
            .strobe    (count_en),
            .prev_carry(sect_carry[s-1]),
            .mode      (mode),
            .inc       (sect_inc[s])
         );
      end

      divchain_section #(
         .W(SECT_W)
      ) sect_i (
         .clk  (clk),
         .rst  (rst),
         .inc  (sect_inc[s]),
         .q    (stages_q[s*SECT_W +: SECT_W]),
         .carry(sect_carry[s])
      );
   end

   divchain_osc_gate osc_i (
      .clk (clk),
      .rst (rst),
      .hold(osc_hold)
   );

   assign count_dbg = stages_q;
   assign tap_out   = stages_q[STAGES-1 -: TAP_N];
endmodule

// File: rtl/divchain_chk.sv
module divchain_chk #(
   parameter int SECT_W = 8,
   parameter int N_SECT = 3,
   parameter int STAGES = 24
) (
   input logic              clk,
   input logic              rst,
   input logic              count_en,
   input logic              test_mode,
   input logic [STAGES-1:0] count_dbg,
   input logic              osc_hold
);
   always @(posedge clk) begin
      if (rst) begin
         AST_RESET_ZERO: assert (count_dbg == '0) else $error("reset count"); // R1
         AST_HOLD_IN_RESET: assert (osc_hold) else $error("hold low in reset"); // R2
      end
   end

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
      !count_en |=> $stable(count_dbg)) else $error("count moved without strobe"); // R3

   AST_SERIAL_STEP: assert property (@(posedge clk) disable iff (rst)
      (count_en && !test_mode) |=> (count_dbg == STAGES'($past(count_dbg) + 1'b1)))
      else $error("serial step wrong"); // R3

   for (genvar s = 0; s < N_SECT; s++) begin : g_sect_chk
      AST_SECTION_STEP: assert property (@(posedge clk) disable iff (rst)
         (count_en && test_mode) |=>
         (count_dbg[s*SECT_W +: SECT_W] == SECT_W'($past(count_dbg[s*SECT_W +: SECT_W]) + 1'b1)))
         else $error("section step wrong"); // R5
   end
endmodule

bind divchain_top divchain_chk #(
   .SECT_W(SECT_W),
   .N_SECT(N_SECT),
   .STAGES(STAGES)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .count_en (count_en),
   .test_mode(test_mode),
   .count_dbg(count_dbg),
   .osc_hold (osc_hold)
);

// File: tb/divchain_top_tb_top.sv
`timescale 1ns/1ps
module divchain_top_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        count_en;
   logic        test_mode;
   logic [6:0]  tap_out;
   logic [23:0] count_dbg;
   logic        osc_hold;

   always #2.5 clk = ~clk;

   divchain_top dut_i (
      .clk      (clk),
      .rst      (rst),
      .count_en (count_en),
      .test_mode(test_mode),
      .tap_out  (tap_out),
      .count_dbg(count_dbg),
      .osc_hold (osc_hold)
   );

   typedef struct {
      logic [23:0] exp;
      string       tag;
   } item_t;

   item_t       sb_q[$];
   logic [23:0] model;
   int          n_chk = 0;
   int          n_err = 0;

   task automatic check(input bit ok, input string tag, input logic [23:0] act,
                        input logic [23:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic en, input logic tm, input bit chk, input string tag);
      @(negedge clk);
      count_en  = en;
      test_mode = tm;
      if (en) begin
         if (tm) begin
            for (int s = 0; s < 3; s++) model[s*8 +: 8] = model[s*8 +: 8] + 8'd1;
         end else begin
            model = model + 24'd1;
         end
      end
      if (chk) sb_q.push_back('{model, tag});
   endtask

   task automatic do_reset();
      @(negedge clk);
      count_en = 1'b0;
      rst      = 1'b1;
      model    = '0;
      #1;
      check(count_dbg == 24'd0, "R1 mid-run reset", count_dbg, 24'd0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // monitor: compare one queued result just after each rising edge
   initial begin
      item_t it;
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            check(count_dbg == it.exp, it.tag, count_dbg, it.exp);
            check(tap_out == it.exp[23:17], "R4 taps", {17'd0, tap_out},
                  {17'd0, it.exp[23:17]});
         end
      end
   end

   initial begin
      rst       = 1'b1;
      count_en  = 1'b0;
      test_mode = 1'b0;
      model     = '0;
      fork
         begin
            repeat (3) @(negedge clk);
            check(count_dbg == 24'd0, "R1 reset count", count_dbg, 24'd0);
            check(tap_out == 7'd0, "R1 reset taps", {17'd0, tap_out}, 24'd0);
            check(osc_hold == 1'b1, "R2 hold in reset", {23'd0, osc_hold}, 24'd1);
            // R8: strobes during reset
            count_en = 1'b1;
            repeat (3) @(negedge clk);
            check(count_dbg == 24'd0, "R8 strobes in reset", count_dbg, 24'd0);
            count_en = 1'b0;
            rst      = 1'b0;
            #1;
            check(osc_hold == 1'b1, "R2 hold before edge", {23'd0, osc_hold}, 24'd1);
            @(posedge clk);
            #1;
            check(osc_hold == 1'b0, "R2 hold released", {23'd0, osc_hold}, 24'd0);

            // R3 serial counting and idle cycles
            for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1, "R3 step");
            for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b1, "R3 idle");
            // R7 mode changes without strobe
            step(1'b0, 1'b1, 1'b1, "R7 to test");
            step(1'b0, 1'b0, 1'b1, "R7 to serial");

            // R6 full exercise sequence
            do_reset();
            for (int i = 0; i < 255; i++) step(1'b1, 1'b1, 1'b1, "R6 test fill");
            step(1'b1, 1'b0, 1'b1, "R6 ripple to zero");
            step(1'b0, 1'b0, 1'b1, "R6 settle");

            // R5 independent section wrap
            do_reset();
            for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, "R5 sections");
            for (int i = 0; i < 252; i++) step(1'b1, 1'b0, 1'b0, "");
            step(1'b0, 1'b0, 1'b1, "R5 preset 0303FF");
            step(1'b1, 1'b1, 1'b1, "R5 wrap no carry");
            step(1'b1, 1'b0, 1'b1, "R3 after test");

            // R9 carries across boundaries
            do_reset();
            for (int i = 0; i < 255; i++) step(1'b1, 1'b0, 1'b0, "");
            step(1'b1, 1'b0, 1'b1, "R9 carry into section 1");
            for (int i = 0; i < 65279; i++) step(1'b1, 1'b0, 1'b0, "");
            step(1'b1, 1'b0, 1'b1, "R9 carry into section 2");
            step(1'b0, 1'b0, 1'b1, "R9 hold");
            do_reset();
            step(1'b0, 1'b0, 1'b1, "R1 after reset");
            repeat (2) @(negedge clk);
         end
         begin
            #1000000;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule